// File: doc/BRIEF.md
# Sign-Magnitude Pipelined Integer Multiplier

This block is the integer multiply unit of a 64-bit execution pipeline. Each cycle it may accept two register operands together with an operation code, a signed flag and a flag that selects the 32-bit forms of the operations. Signed operands are first reduced to their magnitudes. The magnitudes are multiplied by an unsigned multiplier with fixed latency. One negation at the end of the pipeline restores the sign of the product.

An operation tag travels with every product through the pipeline. At the last stage this tag picks which word of the 128-bit product goes to the output, and whether the overflow flag is reported. Because each tag stays with its own product, instructions of different kinds can be issued back to back without the results getting mixed up. A synchronous reset removes every result still in flight.

Top module: `mulsm_unit`

## Requirements
- R1: Operation code 0 (low word) returns bits 63:0 of the full product. Code 3 behaves like code 0.
- R2: With the signed flag set, the product is the two's-complement product of the signed operands. With it clear, both operands are unsigned and the result is never negated, even when their top bits are set.
- R3: With the 32-bit flag set, only bits 31:0 of each operand are used, sign- or zero-extended according to the signed flag. Bits 63:32 of both operands have no effect on the result or on the overflow flag.
- R4: Operation code 1 (high word, 32-bit) returns product bits 63:32 in both bits 63:32 and bits 31:0 of the result.
- R5: Operation code 2 (high word, 64-bit) returns product bits 127:64.
- R6: For code 0 with the 32-bit flag set, the overflow flag is 1 exactly when product bits 63:31 are neither all zeros nor all ones.
- R7: For code 0 with the 32-bit flag clear, the overflow flag is 1 exactly when product bits 127:63 are neither all zeros nor all ones.
- R8: The overflow flag is 0 for codes 1 and 2.
- R9: An operation sampled with in_valid high at a clock edge shows out_valid high for exactly one cycle, DEPTH-1 edges later (the DEPTH-th cycle, counting the issue cycle as the first). A new operation is accepted every cycle, and results come out in issue order, each selected by its own operation code.
- R10: An operand of -2^63 is handled as a magnitude of 2^63. For example, (-2^63) * (-1) with code 0, signed, 64-bit, gives 0x8000000000000000 with overflow set.
- R11: While rst is high at a clock edge, all operations in flight are dropped. out_valid stays low until a new operation has been issued after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Issue strobe |
| in_op | input | 2 | Operation code: 0 low word, 1 high word 32-bit, 2 high word 64-bit |
| in_signed | input | 1 | Operands are signed |
| in_is32 | input | 1 | 32-bit form: only the low operand halves are used |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| out_valid | output | 1 | Result strobe |
| out_result | output | 64 | Selected result word |
| out_overflow | output | 1 | Signed overflow, meaningful for code 0 only |

## Verification
The bench builds the unit with XLEN = 64 and DEPTH = 4. With this depth, four operations with different codes, signedness and widths can be in flight at once, so a mix-up of per-instruction tags shows as a wrong word or a wrong overflow flag. This depth also leaves room to assert reset while two operations are still inside the pipeline. The full 64-bit width reaches the -2^63 magnitude corner and the 127:63 overflow window. The 32-bit forms are exercised with random garbage in the upper operand halves.

// File: rtl/mulsm_pkg.sv
package mulsm_pkg;

  // Operation codes; the encoding is visible on the in_op port.
  typedef enum logic [1:0] {
    MOP_LO   = 2'd0,
    MOP_HI32 = 2'd1,
    MOP_HI64 = 2'd2,
    MOP_RSVD = 2'd3
  } mop_e;

  // Side-band tag carried beside each product.
  typedef struct packed {
    logic valid;
    logic is32;
    logic neg;
    mop_e op;
  } mtag_t;

endpackage

// File: rtl/mulsm_prep.sv
module mulsm_prep #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            in_signed,
  input  logic            in_is32,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] mag_a,
  output logic [XLEN-1:0] mag_b,
  output logic            neg
);
  localparam int HALF = XLEN / 2;

  logic            sgn_a, sgn_b;
  logic [XLEN-1:0] abs_a, abs_b;

  always_comb begin
    sgn_a = in_signed & (in_is32 ? a[HALF-1] : a[XLEN-1]);
    sgn_b = in_signed & (in_is32 ? b[HALF-1] : b[XLEN-1]);
    // The low half of a negation depends only on the low half of its input,
    // so one negator serves both widths.
    abs_a = sgn_a ? (~a + 1'b1) : a;
    abs_b = sgn_b ? (~b + 1'b1) : b;
    if (in_is32) begin
      mag_a = {{(XLEN-HALF){1'b0}}, abs_a[HALF-1:0]};
      mag_b = {{(XLEN-HALF){1'b0}}, abs_b[HALF-1:0]};
    end else begin
      mag_a = abs_a;
      mag_b = abs_b;
    end
    neg = sgn_a ^ sgn_b;
  end

  AST_UNSIGNED_NO_NEG: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_signed) |-> !neg); // R2

  AST_UPPER_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_is32) |-> (mag_a[XLEN-1:HALF] == '0 && mag_b[XLEN-1:HALF] == '0)); // R3

endmodule

// File: rtl/mulsm_core.sv
module mulsm_core
  import mulsm_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  mtag_t             tag_i,
  input  logic [XLEN-1:0]   mag_a,
  input  logic [XLEN-1:0]   mag_b,
  output mtag_t             tag_o,
  output logic [2*XLEN-1:0] prod_o
);
  localparam int PW  = 2 * XLEN;
  localparam int NST = DEPTH - 1;   // the output register is the last stage

  mtag_t           tag_q  [NST];
  logic [PW-1:0]   prod_q [NST];

  always_ff @(posedge clk) begin
    prod_q[0] <= PW'(mag_a) * PW'(mag_b);
    tag_q[0]  <= tag_i;
    for (int i = 1; i < NST; i++) begin
      prod_q[i] <= prod_q[i-1];
      tag_q[i]  <= tag_q[i-1];
    end
    if (rst) begin
      for (int i = 0; i < NST; i++) tag_q[i].valid <= 1'b0;
    end
  end

  assign tag_o  = tag_q[NST-1];
  assign prod_o = prod_q[NST-1];

  AST_ISSUE_ENTERS: assert property (@(posedge clk) disable iff (rst)
    tag_i.valid |=> tag_q[0].valid); // R9

  for (genvar g = 1; g < NST; g++) begin : g_adv
    AST_STAGE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
      tag_q[g-1].valid |=> tag_q[g].valid); // R9
  end

endmodule

// File: rtl/mulsm_result.sv
module mulsm_result
  import mulsm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  mtag_t             tag,
  input  logic [2*XLEN-1:0] prod,
  output logic              valid_o,
  output logic [XLEN-1:0]   res_o,
  output logic              ovf_o
);
  localparam int PW   = 2 * XLEN;
  localparam int HALF = XLEN / 2;

  logic [PW-1:0]   fin;
  logic            ov_narrow, ov_wide;
  logic [XLEN-1:0] sel;
  logic            ovf;

  always_comb begin
    fin       = tag.neg ? (~prod + 1'b1) : prod;
    ov_narrow = (|fin[XLEN-1:HALF-1]) & ~(&fin[XLEN-1:HALF-1]);
    ov_wide   = (|fin[PW-1:XLEN-1])   & ~(&fin[PW-1:XLEN-1]);
    case (tag.op)
      MOP_HI32: begin
        sel = {fin[XLEN-1:HALF], fin[XLEN-1:HALF]};
        ovf = 1'b0;
      end
      MOP_HI64: begin
        sel = fin[PW-1:XLEN];
        ovf = 1'b0;
      end
      default: begin
        sel = fin[XLEN-1:0];
        ovf = tag.is32 ? ov_narrow : ov_wide;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    valid_o <= rst ? 1'b0 : tag.valid;
    res_o   <= sel;
    ovf_o   <= ovf;
  end

  AST_NO_OVERFLOW_HIGH: assert property (@(posedge clk) disable iff (rst)
    (tag.valid && (tag.op == MOP_HI32 || tag.op == MOP_HI64)) |=> !ovf_o); // R8

  AST_HI32_MIRROR: assert property (@(posedge clk) disable iff (rst)
    (tag.valid && tag.op == MOP_HI32) |=> (res_o[XLEN-1:HALF] == res_o[HALF-1:0])); // R4

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !valid_o); // R11

endmodule

// File: rtl/mulsm_unit.sv
module mulsm_unit
  import mulsm_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int DEPTH = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [1:0]      in_op,
  input  logic            in_signed,
  input  logic            in_is32,
  input  logic [XLEN-1:0] in_a,
  input  logic [XLEN-1:0] in_b,
  output logic            out_valid,
  output logic [XLEN-1:0] out_result,
  output logic            out_overflow
);
  localparam int PW = 2 * XLEN;

  logic [XLEN-1:0] mag_a, mag_b;
  logic            neg;
  mtag_t           tag_in, tag_last;
  logic [PW-1:0]   prod_last;

  mulsm_prep #(.XLEN(XLEN)) u_prep (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_signed (in_signed),
    .in_is32   (in_is32),
    .a         (in_a),
    .b         (in_b),
    .mag_a     (mag_a),
    .mag_b     (mag_b),
    .neg       (neg)
  );

  always_comb begin
    tag_in.valid = in_valid;
    tag_in.is32  = in_is32;
    tag_in.neg   = neg;
    tag_in.op    = mop_e'(in_op);
  end

  mulsm_core #(.XLEN(XLEN), .DEPTH(DEPTH)) u_core (
    .clk    (clk),
    .rst    (rst),
    .tag_i  (tag_in),
    .mag_a  (mag_a),
    .mag_b  (mag_b),
    .tag_o  (tag_last),
    .prod_o (prod_last)
  );

  mulsm_result #(.XLEN(XLEN)) u_result (
    .clk     (clk),
    .rst     (rst),
    .tag     (tag_last),
    .prod    (prod_last),
    .valid_o (out_valid),
    .res_o   (out_result),
    .ovf_o   (out_overflow)
  );

endmodule

// File: tb/tb_mulsm_unit.sv
module tb_mulsm_unit;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  in_op = 2'd0;
  logic        in_signed = 1'b0;
  logic        in_is32 = 1'b0;
  logic [63:0] in_a = '0;
  logic [63:0] in_b = '0;
  logic        out_valid;
  logic [63:0] out_result;
  logic        out_overflow;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;

  typedef struct {
    logic [63:0] res;
    logic        ovf;
    int          cyc;
    string       req;
  } item_t;

  item_t q[$];

  mulsm_unit #(.XLEN(64), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_signed(in_signed), .in_is32(in_is32), .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_result(out_result), .out_overflow(out_overflow)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  // Reference model from the requirements: full-width modular product.
  function automatic item_t model(input logic [1:0] op, input logic sg, input logic w32,
                                  input logic [63:0] a, input logic [63:0] b);
    item_t it;
    logic [127:0] xa, xb, p;
    if (w32) begin
      xa = sg ? {{96{a[31]}}, a[31:0]} : {96'b0, a[31:0]};
      xb = sg ? {{96{b[31]}}, b[31:0]} : {96'b0, b[31:0]};
    end else begin
      xa = sg ? {{64{a[63]}}, a} : {64'b0, a};
      xb = sg ? {{64{b[63]}}, b} : {64'b0, b};
    end
    p = xa * xb;
    case (op)
      2'd1: begin it.res = {p[63:32], p[63:32]}; it.ovf = 1'b0; end
      2'd2: begin it.res = p[127:64]; it.ovf = 1'b0; end
      default: begin
        it.res = p[63:0];
        if (w32) it.ovf = (p[63:31] != '0) && (p[63:31] != '1);
        else     it.ovf = (p[127:63] != '0) && (p[127:63] != '1);
      end
    endcase
    return it;
  endfunction

  // Driver: one issue per call, back to back when called consecutively.
  task automatic issue(input logic [1:0] op, input logic sg, input logic w32,
                       input logic [63:0] a, input logic [63:0] b, input string req);
    item_t it;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_signed = sg; in_is32 = w32; in_a = a; in_b = b;
    it = model(op, sg, w32, a, b);
    it.cyc = cyc + DEPTH;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_a = {$urandom, $urandom};
      in_b = {$urandom, $urandom};
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    item_t it;
    if (!rst && out_valid) begin
      if (q.size() == 0) begin
        chk(1'b0, "R9 unexpected out_valid", {63'b0, out_valid}, 64'd0);
      end else begin
        it = q.pop_front();
        chk(out_result === it.res, {it.req, " result"}, out_result, it.res);
        chk(out_overflow === it.ovf, {it.req, " overflow"}, {63'b0, out_overflow}, {63'b0, it.ovf});
        chk(cyc == it.cyc, "R9 latency", 64'(cyc), 64'(it.cyc));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 64'(cyc), 64'd0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11 reset state", {63'b0, out_valid}, 64'd0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(out_valid === 1'b0, "R11 idle after reset", {63'b0, out_valid}, 64'd0);

    // Directed cases, issued back to back with mixed codes (R9)
    issue(2'd0, 0, 0, 64'h1000, 64'h1111, "R1 low unsigned");
    issue(2'd0, 1, 0, -64'sd3, 64'd5, "R2 signed low");
    issue(2'd2, 0, 0, '1, '1, "R5 high64 unsigned");
    issue(2'd0, 0, 0, '1, '1, "R2 unsigned top bits");
    issue(2'd2, 1, 0, '1, '1, "R5 high64 signed");
    issue(2'd2, 1, 0, 64'h8000000000000000, 64'd2, "R5 high64 min");
    issue(2'd0, 1, 1, 64'hDEADBEEF_FFFFFFFE, 64'h12345678_00000003, "R3 upper ignored");
    issue(2'd0, 1, 1, 64'h40000000, 64'd2, "R6 narrow overflow");
    issue(2'd0, 0, 1, 64'hFFFFFFFF, 64'hFFFFFFFF, "R6 narrow unsigned");
    issue(2'd0, 1, 1, 64'h5555_5555_FFFF_FFFF, 64'hAAAA_AAAA_0000_0001, "R6 narrow no overflow");
    issue(2'd1, 1, 1, 64'hFFFFFFFE, 64'h00000003, "R4 high32 signed");
    issue(2'd1, 0, 1, 64'hABCD0000_80000000, 64'h4, "R4 high32 unsigned");
    issue(2'd1, 1, 0, 64'h7FFFFFFF_FFFFFFFF, 64'h7FFFFFFF_FFFFFFFF, "R8 high32 no overflow");
    issue(2'd0, 1, 0, 64'h4000000000000000, 64'd2, "R7 wide overflow");
    issue(2'd0, 1, 0, 64'hC000000000000000, 64'd2, "R7 wide no overflow");
    issue(2'd2, 1, 0, 64'h8000000000000000, 64'h8000000000000000, "R8 high64 no overflow");
    issue(2'd0, 1, 0, 64'h8000000000000000, '1, "R10 most negative");
    issue(2'd3, 1, 0, -64'sd7, 64'd9, "R1 code 3 as low");
    idle(DEPTH + 2);

    // Random mix with gaps
    for (int k = 0; k < 400; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 2));
      issue(op, 1'($urandom), 1'($urandom), {$urandom, $urandom}, {$urandom, $urandom},
            (op == 2'd0) ? "R1 random low" : (op == 2'd1) ? "R4 random high32" : "R5 random high64");
      if ($urandom_range(0, 3) == 0) idle(1);
    end
    idle(DEPTH + 2);

    // Reset with two operations in flight (R11)
    issue(2'd0, 0, 0, 64'd6, 64'd7, "R11 dropped");
    issue(2'd2, 0, 0, '1, 64'd3, "R11 dropped");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    q.delete();
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < DEPTH + 2; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R11 in-flight dropped", {63'b0, out_valid}, 64'd0);
    end
    issue(2'd0, 1, 0, -64'sd4, -64'sd4, "R11 after reset");
    idle(DEPTH + 2);

    chk(q.size() == 0, "R9 all results delivered", 64'(q.size()), 64'd0);
    finish_run();
  end

endmodule